// File: doc/BRIEF.md
# Sector Erase Command Window Timer

This block gathers sector erase requests inside a flash command controller before the erase algorithm runs. The bus decoder gives it a one-cycle pulse for every completed sector erase command sequence, together with the sector address. It also gives it a separate pulse for a chip erase command. Each accepted sector is marked in a bitmap. A time-out window runs while requests are being gathered, and every further accepted sector request starts that window again from its full length.

When the window runs out, the block raises a one-cycle erase-start pulse and sets a status bit that tells software the window has closed. From then on only suspend and resume requests change its state, until the erase algorithm reports completion. A chip erase request skips the window and starts at once. The window length is set in clock cycles, computed from the clock frequency in MHz and the window length in microseconds (nominally 50).

Top module: `erase_window_timer`

## Requirements
- R1: After reset, `busy`, `windowClosed`, `suspended`, `eraseStart` and `chipErase` are 0, and `eraseMask` is all zeros.
- R2: A `sectorCmd` pulse while the block is idle sets bit `sectorAddr` of `eraseMask` (bit i stands for sector i). From the next cycle on it also drives `busy` to 1, while `windowClosed` stays 0.
- R3: Let W be `CLK_MHZ*WINDOW_US`. Exactly W cycles after the clock edge that accepted the latest sector command, `windowClosed` becomes 1 and `eraseStart` is 1 for exactly one cycle. Before that edge both read 0.
- R4: A `sectorCmd` accepted while the window is open adds its bit to `eraseMask`, keeps the earlier bits, and restarts the full W-cycle window from its own edge.
- R5: A `sectorCmd` that arrives on the same edge at which the window expires is rejected: its bit is not set and the expiry timing does not change.
- R6: While the window is closed, `sectorCmd` and `chipCmd` have no effect. `eraseMask` and `chipErase` stay as they were, and no further `eraseStart` pulse is given.
- R7: A `chipCmd` while idle starts the erase on the next edge with no window. `eraseStart` is then 1 for one cycle, and `chipErase`, `windowClosed` and `busy` read 1.
- R8: A `chipCmd` while the sector window is open is ignored: `chipErase` stays 0 and the window is not restarted.
- R9: `suspendCmd` during an erase sets `suspended` to 1 and `busy` to 0, and `windowClosed` stays 1. While suspended, `eraseDone` and sector commands are ignored. `resumeCmd` then returns `busy` to 1 and clears `suspended`, with no new `eraseStart`.
- R10: `eraseDone` during a running erase returns the block to idle on the next edge. After that edge `busy`, `windowClosed` and `chipErase` read 0 and `eraseMask` is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sectorCmd | input | 1 | One-cycle pulse: a sector erase command has completed |
| sectorAddr | input | ADDR_W | Sector index that goes with `sectorCmd` |
| chipCmd | input | 1 | One-cycle pulse: a chip erase command has completed |
| suspendCmd | input | 1 | Erase suspend request |
| resumeCmd | input | 1 | Erase resume request |
| eraseDone | input | 1 | The erase algorithm has finished |
| eraseStart | output | 1 | One-cycle pulse when the erase begins |
| eraseMask | output | NUM_SECTORS | Bitmap of the sectors selected for erase |
| chipErase | output | 1 | The running erase is a whole-chip erase |
| windowClosed | output | 1 | Status bit: 0 while commands are being gathered, 1 once the erase has begun |
| busy | output | 1 | A window or an erase is in progress (and not suspended) |
| suspended | output | 1 | The erase is suspended |

## Verification
Every command is sampled on one rising edge. Its effect on `eraseMask`, `busy`, `chipErase` and `suspended` is due right after that edge. The expiry outputs `windowClosed` and `eraseStart` are due exactly W edges after the last accepted sector command, and `eraseStart` falls again one edge later. The bench drives inputs and reads outputs on falling edges, counting edges from the accepting edge. It checks that the status is still low on each of the W-1 edges before expiry and high on the W-th. The gap between two sector commands is swept over every value from 1 to W, and W itself is the rejected case.

// File: rtl/ewt_pkg.sv
package ewt_pkg;

  typedef enum logic [1:0] {
    ST_IDLE    = 2'd0,
    ST_WINDOW  = 2'd1,
    ST_ERASING = 2'd2,
    ST_SUSPEND = 2'd3
  } ewtState_t;

  typedef struct packed {
    logic cntLoad;     // reload the window counter
    logic maskSet;     // record the sector on the address bus
    logic maskClear;   // drop the bitmap and the chip flag
    logic chipSet;     // mark a whole-chip erase
    logic startPulse;  // erase begins on this edge
  } ewtStrobe_t;

endpackage

// File: rtl/ewt_ctrl.sv
module ewt_ctrl
  import ewt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sectorCmd,
  input  logic       chipCmd,
  input  logic       suspendCmd,
  input  logic       resumeCmd,
  input  logic       eraseDone,
  input  logic       cntZero,
  output ewtStrobe_t strobe,
  output logic       windowClosed,
  output logic       busy,
  output logic       suspended
);

  ewtState_t state, stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (sectorCmd) begin
          strobe.cntLoad = 1'b1;
          strobe.maskSet = 1'b1;
          stateNext      = ST_WINDOW;
        end else if (chipCmd) begin
          strobe.chipSet    = 1'b1;
          strobe.startPulse = 1'b1;
          stateNext         = ST_ERASING;
        end
      end
      ST_WINDOW: begin
        if (cntZero) begin
          strobe.startPulse = 1'b1;
          stateNext         = ST_ERASING;
        end else if (sectorCmd) begin
          strobe.cntLoad = 1'b1;
          strobe.maskSet = 1'b1;
        end
      end
      ST_ERASING: begin
        if (eraseDone) begin
          strobe.maskClear = 1'b1;
          stateNext        = ST_IDLE;
        end else if (suspendCmd) begin
          stateNext = ST_SUSPEND;
        end
      end
      ST_SUSPEND: begin
        if (resumeCmd) stateNext = ST_ERASING;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign windowClosed = (state == ST_ERASING) || (state == ST_SUSPEND);
  assign busy         = (state == ST_WINDOW)  || (state == ST_ERASING);
  assign suspended    = (state == ST_SUSPEND);

  assert_expiry_R3: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && cntZero) |=> (state == ST_ERASING));

  assert_closed_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASING && !eraseDone && !suspendCmd) |=> (state == ST_ERASING));

  assert_suspend_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSPEND && !resumeCmd) |=> (state == ST_SUSPEND));

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASING && eraseDone) |=> (state == ST_IDLE));

endmodule

// File: rtl/ewt_datapath.sv
module ewt_datapath
  import ewt_pkg::*;
#(
  parameter int NUM_SECTORS   = 8,
  parameter int ADDR_W        = 3,
  parameter int WINDOW_CYCLES = 5000,
  localparam int CNT_W        = $clog2(WINDOW_CYCLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ewtStrobe_t             strobe,
  input  logic [ADDR_W-1:0]      sectorAddr,
  output logic                   cntZero,
  output logic                   eraseStart,
  output logic [NUM_SECTORS-1:0] eraseMask,
  output logic                   chipErase
);

  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WINDOW_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN)               cnt <= '0;
    else if (strobe.cntLoad) cnt <= LOAD_VAL;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign cntZero = (cnt == '0);

  for (genvar i = 0; i < NUM_SECTORS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rstN || strobe.maskClear)
        eraseMask[i] <= 1'b0;
      else if (strobe.maskSet && sectorAddr == ADDR_W'(i))
        eraseMask[i] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chipErase  <= 1'b0;
      eraseStart <= 1'b0;
    end else begin
      eraseStart <= strobe.startPulse;
      if (strobe.maskClear)    chipErase <= 1'b0;
      else if (strobe.chipSet) chipErase <= 1'b1;
    end
  end

  assert_single_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart);

  assert_reload_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cntLoad |=> !cntZero || (WINDOW_CYCLES == 1));

endmodule

// File: rtl/erase_window_timer.sv
module erase_window_timer
  import ewt_pkg::*;
#(
  parameter int NUM_SECTORS = 8,
  parameter int CLK_MHZ     = 100,
  parameter int WINDOW_US   = 50,
  localparam int ADDR_W        = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int WINDOW_CYCLES = CLK_MHZ * WINDOW_US
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sectorCmd,
  input  logic [ADDR_W-1:0]      sectorAddr,
  input  logic                   chipCmd,
  input  logic                   suspendCmd,
  input  logic                   resumeCmd,
  input  logic                   eraseDone,
  output logic                   eraseStart,
  output logic [NUM_SECTORS-1:0] eraseMask,
  output logic                   chipErase,
  output logic                   windowClosed,
  output logic                   busy,
  output logic                   suspended
);

  ewtStrobe_t strobe;
  logic       cntZero;

  ewt_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .sectorCmd    (sectorCmd),
    .chipCmd      (chipCmd),
    .suspendCmd   (suspendCmd),
    .resumeCmd    (resumeCmd),
    .eraseDone    (eraseDone),
    .cntZero      (cntZero),
    .strobe       (strobe),
    .windowClosed (windowClosed),
    .busy         (busy),
    .suspended    (suspended)
  );

  ewt_datapath #(
    .NUM_SECTORS   (NUM_SECTORS),
    .ADDR_W        (ADDR_W),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .sectorAddr (sectorAddr),
    .cntZero    (cntZero),
    .eraseStart (eraseStart),
    .eraseMask  (eraseMask),
    .chipErase  (chipErase)
  );

  assert_status_with_start_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowClosed) |-> eraseStart);

  assert_chip_no_window_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(chipErase) |-> windowClosed);

  assert_idle_clear_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !windowClosed && !suspended) |-> (eraseMask == '0 && !chipErase));

endmodule

// File: tb/erase_window_timer_bench.sv
module erase_window_timer_bench;
  localparam int NS = 8;
  localparam int W  = 6;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          sectorCmd = 1'b0, chipCmd = 1'b0, suspendCmd = 1'b0;
  logic          resumeCmd = 1'b0, eraseDone = 1'b0;
  logic [2:0]    sectorAddr = '0;
  logic          eraseStart, chipErase, windowClosed, busy, suspended;
  logic [NS-1:0] eraseMask;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  erase_window_timer #(.NUM_SECTORS(NS), .CLK_MHZ(1), .WINDOW_US(W)) u_erase_window_timer (
    .clk(clk), .rstN(rstN), .sectorCmd(sectorCmd), .sectorAddr(sectorAddr),
    .chipCmd(chipCmd), .suspendCmd(suspendCmd), .resumeCmd(resumeCmd),
    .eraseDone(eraseDone), .eraseStart(eraseStart), .eraseMask(eraseMask),
    .chipErase(chipErase), .windowClosed(windowClosed), .busy(busy),
    .suspended(suspended)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendSector(input int s);
    sectorAddr = 3'(s); sectorCmd = 1'b1; step(1); sectorCmd = 1'b0;
  endtask

  task automatic sendChip();    chipCmd = 1'b1;    step(1); chipCmd = 1'b0;    endtask
  task automatic sendSuspend(); suspendCmd = 1'b1; step(1); suspendCmd = 1'b0; endtask
  task automatic sendResume();  resumeCmd = 1'b1;  step(1); resumeCmd = 1'b0;  endtask

  task automatic finishErase();
    eraseDone = 1'b1; step(1); eraseDone = 1'b0;
    chk("R10 mask cleared", 32'(eraseMask), 32'h0);
    chk("R10 busy low", 32'(busy), 32'h0);
    chk("R10 status low", 32'(windowClosed), 32'h0);
    chk("R10 chip flag low", 32'(chipErase), 32'h0);
  endtask

  // The caller sits right after the accepting edge; this follows the window to expiry.
  task automatic expectExpiry(input string req, input logic [NS-1:0] mask);
    for (int j = 1; j < W; j++) begin
      step(1);
      chk({req, " status still 0"}, 32'(windowClosed), 32'h0);
      chk({req, " no start yet"}, 32'(eraseStart), 32'h0);
    end
    step(1);
    chk({req, " status 1 at W"}, 32'(windowClosed), 32'h1);
    chk({req, " start pulse at W"}, 32'(eraseStart), 32'h1);
    chk({req, " mask at expiry"}, 32'(eraseMask), 32'(mask));
    step(1);
    chk({req, " start one cycle"}, 32'(eraseStart), 32'h0);
  endtask

  initial begin
    step(2);
    rstN = 1'b1;
    // R1
    chk("R1 busy", 32'(busy), 32'h0);
    chk("R1 status", 32'(windowClosed), 32'h0);
    chk("R1 suspended", 32'(suspended), 32'h0);
    chk("R1 start", 32'(eraseStart), 32'h0);
    chk("R1 chip", 32'(chipErase), 32'h0);
    chk("R1 mask", 32'(eraseMask), 32'h0);

    // R2 and R3: every sector alone
    for (int s = 0; s < NS; s++) begin
      sendSector(s);
      chk("R2 mask bit", 32'(eraseMask), 32'(1 << s));
      chk("R2 busy", 32'(busy), 32'h1);
      chk("R2 status 0", 32'(windowClosed), 32'h0);
      expectExpiry("R3", NS'(1 << s));
      finishErase();
    end

    // R4: every gap from 1 to W-1 restarts the window
    for (int g = 1; g < W; g++) begin
      sendSector(0);
      step(g - 1);
      sendSector(g);
      chk("R4 both bits", 32'(eraseMask), 32'(1 | (1 << g)));
      expectExpiry("R4", NS'(1 | (1 << g)));
      finishErase();
    end

    // R5: command on the expiry edge is rejected
    sendSector(1);
    step(W - 1);
    sendSector(2);
    chk("R5 status 1", 32'(windowClosed), 32'h1);
    chk("R5 start pulse", 32'(eraseStart), 32'h1);
    chk("R5 mask unchanged", 32'(eraseMask), 32'h2);

    // R6: commands ignored while closed
    sendSector(5);
    chk("R6 mask unchanged", 32'(eraseMask), 32'h2);
    chk("R6 no new start", 32'(eraseStart), 32'h0);
    sendChip();
    chk("R6 chip ignored", 32'(chipErase), 32'h0);
    chk("R6 no start after chip", 32'(eraseStart), 32'h0);
    chk("R6 still closed", 32'(windowClosed), 32'h1);

    // R9: suspend and resume
    sendSuspend();
    chk("R9 suspended", 32'(suspended), 32'h1);
    chk("R9 busy low", 32'(busy), 32'h0);
    chk("R9 status stays 1", 32'(windowClosed), 32'h1);
    sendSector(6);
    chk("R9 sector ignored", 32'(eraseMask), 32'h2);
    eraseDone = 1'b1; step(1); eraseDone = 1'b0;
    chk("R9 done ignored", 32'(suspended), 32'h1);
    chk("R9 mask kept", 32'(eraseMask), 32'h2);
    sendResume();
    chk("R9 resumed", 32'(suspended), 32'h0);
    chk("R9 busy again", 32'(busy), 32'h1);
    chk("R9 no start on resume", 32'(eraseStart), 32'h0);
    finishErase();

    // R7: chip erase has no window
    sendChip();
    chk("R7 start pulse", 32'(eraseStart), 32'h1);
    chk("R7 chip flag", 32'(chipErase), 32'h1);
    chk("R7 status 1", 32'(windowClosed), 32'h1);
    chk("R7 busy", 32'(busy), 32'h1);
    step(1);
    chk("R7 start one cycle", 32'(eraseStart), 32'h0);
    finishErase();

    // R8: chip command inside the window is ignored and does not restart it
    sendSector(3);
    sendChip();
    chk("R8 chip flag low", 32'(chipErase), 32'h0);
    for (int j = 2; j < W; j++) begin
      step(1);
      chk("R8 status still 0", 32'(windowClosed), 32'h0);
    end
    step(1);
    chk("R8 expiry unchanged", 32'(windowClosed), 32'h1);
    chk("R8 start", 32'(eraseStart), 32'h1);
    chk("R8 mask", 32'(eraseMask), 32'h8);
    finishErase();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule